// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is the small translation cache of a memory management unit. It holds recent virtual-page to physical-page mappings, each with its permission bits, so that most translations finish without touching the page table in memory. A lookup port takes a virtual address. One cycle later the block reports hit or miss, and on a hit it also returns the physical address (the cached physical page joined to the untouched page offset) and the permission bits.

After a page-table walk outside this block, a fill port writes a complete entry. A flush input drops every cached mapping at once. The default geometry is 16 entries: 4 sets of 4 ways each, with 14-bit virtual addresses, 64-byte pages and 6-bit physical page numbers.

Within a set, a fill lands in one of three places, in this order of preference: the way already holding the same tag, then the lowest-numbered empty way, then the way chosen by a round-robin pointer kept separately for each set.

Top module: `tlb_sa`

## Requirements
- R1: After reset `rsp_valid` is low and every entry is invalid, so the first lookups miss.
- R2: A lookup address splits into a page offset in bits 5:0, a set index in bits 7:6 and a tag in bits 13:8. The fill page number `fill_vpn` carries the set index in bits 1:0 and the tag in bits 7:2.
- R3: A lookup hits when a valid way of the indexed set holds the lookup tag. On a hit, `rsp_paddr` is the stored physical page in bits 11:6 and the lookup offset in bits 5:0, and `rsp_perm` is the stored permission field.
- R4: On a miss, `rsp_hit`, `rsp_paddr` and `rsp_perm` are all zero.
- R5: The result of a lookup appears in the cycle after `lk_valid` is sampled high, with `rsp_valid` high. In a cycle after `lk_valid` was low, `rsp_valid` and `rsp_hit` are low.
- R6: A lookup sees the contents from before any fill or flush in the same cycle. A fill is seen by the lookups that follow it.
- R7: A fill whose tag is already valid in its set overwrites that way, so a tag is never held twice in one set.
- R8: A fill into a set that has an invalid way, and no matching tag, writes the lowest-numbered invalid way.
- R9: A fill into a full set with no matching tag replaces the way named by that set's pointer. The pointer starts at way 0 after reset and advances by one, wrapping, after each such replacement. The pointers of other sets do not move.
- R10: Flush invalidates every entry in one cycle and the pointers are kept. A fill in the same cycle as a flush is discarded.
- R11: After page 0x0F is filled with physical page 0x0D, address 0x03D4 hits and translates to 0x354, and address 0x0020 still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 14 | Lookup virtual address |
| fill_valid | input | 1 | Write an entry |
| fill_vpn | input | 8 | Virtual page number of the entry |
| fill_ppn | input | 6 | Physical page number of the entry |
| fill_perm | input | 3 | Permission bits of the entry |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 12 | Translated physical address |
| rsp_perm | output | 3 | Permission bits of the hit entry |

## Verification
All results are due exactly one clock edge after the request. The lookup result registers at the edge that samples `lk_valid`, and a fill or flush changes the array at that same edge. The bench applies each stimulus at a falling edge and predicts the response from its own model before it applies the update. It compares at the next falling edge, then commits the update to the model. That way a same-cycle fill or flush is checked against the old contents, and the next lookup against the new.

// File: rtl/tlb_sa.sv
`timescale 1ns/1ps
module tlb_sa #(
  parameter int VA_W   = 14,
  parameter int OFS_W  = 6,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PA_W  = PPN_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm
);

  logic [WAYS-1:0]   v_q    [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]  ppn_q  [SETS][WAYS];
  logic [PERM_W-1:0] perm_q [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q   [SETS];

  wire [IDX_W-1:0] idx_l = lk_vaddr[OFS_W +: IDX_W];
  wire [TAG_W-1:0] tag_l = lk_vaddr[OFS_W+IDX_W +: TAG_W];
  wire [IDX_W-1:0] idx_f = fill_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] tag_f = fill_vpn[IDX_W +: TAG_W];
  wire             do_fill = fill_valid && !flush;

  logic [WAYS-1:0]   match_l;
  logic [PPN_W-1:0]  hit_ppn;
  logic [PERM_W-1:0] hit_perm;

  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      match_l[w] = v_q[idx_l][w] && (tag_q[idx_l][w] == tag_l);
      if (match_l[w]) begin
        hit_ppn  = hit_ppn  | ppn_q[idx_l][w];
        hit_perm = hit_perm | perm_q[idx_l][w];
      end
    end
  end

  wire hit_l = |match_l;

  logic             dup_any, inv_any;
  logic [WAY_W-1:0] dup_way, inv_way, victim;

  always_comb begin
    dup_any = 1'b0;
    inv_any = 1'b0;
    dup_way = '0;
    inv_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (v_q[idx_f][w] && tag_q[idx_f][w] == tag_f) begin
        dup_any = 1'b1;
        dup_way = WAY_W'(w);
      end
      if (!v_q[idx_f][w]) begin
        inv_any = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
    if (dup_any)      victim = dup_way;
    else if (inv_any) victim = inv_way;
    else              victim = rr_q[idx_f];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= '{default: '0};
      rr_q      <= '{default: '0};
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && hit_l;
      rsp_paddr <= (lk_valid && hit_l) ? {hit_ppn, lk_vaddr[OFS_W-1:0]} : '0;
      rsp_perm  <= (lk_valid && hit_l) ? hit_perm : '0;
      if (flush) begin
        v_q <= '{default: '0};
      end else if (fill_valid) begin
        v_q[idx_f][victim] <= 1'b1;
        if (!dup_any && !inv_any)
          rr_q[idx_f] <= (rr_q[idx_f] == WAY_W'(WAYS-1)) ? '0 : rr_q[idx_f] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[idx_f][victim]  <= tag_f;
      ppn_q[idx_f][victim]  <= fill_ppn;
      perm_q[idx_f][victim] <= fill_perm;
    end
  end

  p_unique_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_l));

  p_rsp_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  p_rsp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit));

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));

  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_perm == '0));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 lk_valid |=> !rsp_hit);

endmodule

// File: tb/test_tlb_sa.sv
`timescale 1ns/1ps
module test_tlb_sa;
  localparam int NS = 4, NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [13:0] lk_vaddr = '0;
  logic        fill_valid = 1'b0;
  logic [7:0]  fill_vpn = '0;
  logic [5:0]  fill_ppn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [11:0] rsp_paddr;
  logic [2:0]  rsp_perm;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  bit       m_v    [NS][NW];
  bit [5:0] m_tag  [NS][NW];
  bit [5:0] m_ppn  [NS][NW];
  bit [2:0] m_perm [NS][NW];
  int       m_rr   [NS];

  tlb_sa i_tlb_sa (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm), .flush(flush), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < NS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < NW; w++) m_v[s][w] = 0;
    end
  endfunction

  function automatic void model_fill(input bit [7:0] vpn, input bit [5:0] ppn, input bit [2:0] perm);
    int s = int'(vpn[1:0]);
    int way = -1;
    for (int w = 0; w < NW; w++)
      if (way < 0 && m_v[s][w] && m_tag[s][w] == vpn[7:2]) way = w;
    for (int w = 0; w < NW; w++)
      if (way < 0 && !m_v[s][w]) way = w;
    if (way < 0) begin
      way = m_rr[s];
      m_rr[s] = (m_rr[s] + 1) % NW;
    end
    m_v[s][way] = 1; m_tag[s][way] = vpn[7:2];
    m_ppn[s][way] = ppn; m_perm[s][way] = perm;
  endfunction

  task automatic step(input string req, input bit lkv, input bit [13:0] va,
                      input bit fv, input bit [7:0] fvpn, input bit [5:0] fppn,
                      input bit [2:0] fperm, input bit fl);
    int s, e_hit, e_pa, e_perm;
    lk_valid = lkv; lk_vaddr = va; fill_valid = fv; fill_vpn = fvpn;
    fill_ppn = fppn; fill_perm = fperm; flush = fl;
    s = int'(va[7:6]);
    e_hit = 0; e_pa = 0; e_perm = 0;
    for (int w = 0; w < NW; w++)
      if (lkv && m_v[s][w] && m_tag[s][w] == va[13:8]) begin
        e_hit = 1; e_pa = {m_ppn[s][w], va[5:0]}; e_perm = m_perm[s][w];
      end
    @(posedge clk);
    if (fl) begin
      for (int a = 0; a < NS; a++)
        for (int w = 0; w < NW; w++) m_v[a][w] = 0;
    end else if (fv) model_fill(fvpn, fppn, fperm);
    @(negedge clk);
    check(req, "rsp_valid", int'(rsp_valid), int'(lkv));
    if (lkv) begin
      check(req, "rsp_hit", int'(rsp_hit), e_hit);
      check(req, "rsp_paddr", int'(rsp_paddr), e_pa);
      check(req, "rsp_perm", int'(rsp_perm), e_perm);
    end else check(req, "rsp_hit idle", int'(rsp_hit), 0);
  endtask

  function automatic bit [13:0] va_of(input int tag, input int set, input int ofs);
    return 14'((tag << 8) | (set << 6) | ofs);
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    step("R1", 1, 14'h03D4, 0, 0, 0, 0, 0);
    step("R5", 0, 14'h03D4, 0, 0, 0, 0, 0);
    // R11 worked example
    step("R11", 0, 0, 1, 8'h0F, 6'h0D, 3'b101, 0);
    step("R11", 1, 14'h03D4, 0, 0, 0, 0, 0);
    step("R11", 1, 14'h0020, 0, 0, 0, 0, 0);
    // R6 fill and lookup in the same cycle
    step("R6", 1, 14'h0020, 1, 8'h00, 6'h28, 3'b011, 0);
    step("R6", 1, 14'h0027, 0, 0, 0, 0, 0);
    // R7 overwrite of an existing tag
    step("R7", 0, 0, 1, 8'h0F, 6'h22, 3'b110, 0);
    step("R7", 1, 14'h03D4, 0, 0, 0, 0, 0);
    // R8 / R9 fill order in set 1
    for (int t = 1; t <= 4; t++) step("R8", 0, 0, 1, 8'((t << 2) | 1), 6'(t + 16), 3'(t), 0);
    for (int t = 1; t <= 4; t++) step("R8", 1, va_of(t, 1, 5), 0, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 8'((5 << 2) | 1), 6'h31, 3'b001, 0);
    step("R9", 1, va_of(1, 1, 0), 0, 0, 0, 0, 0);
    step("R9", 1, va_of(2, 1, 0), 0, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 8'((6 << 2) | 1), 6'h32, 3'b010, 0);
    step("R9", 1, va_of(2, 1, 0), 0, 0, 0, 0, 0);
    step("R9", 1, va_of(3, 1, 9), 0, 0, 0, 0, 0);
    step("R2", 1, va_of(3, 0, 9), 0, 0, 0, 0, 0);
    step("R3", 1, va_of(6, 1, 63), 0, 0, 0, 0, 0);
    // R10 flush with fill and lookup in the same cycle
    step("R10", 1, 14'h03D4, 1, 8'h2A, 6'h11, 3'b111, 1);
    step("R10", 1, 14'h03D4, 0, 0, 0, 0, 0);
    step("R10", 1, va_of(10, 2, 0), 0, 0, 0, 0, 0);
    step("R4", 1, va_of(6, 1, 0), 0, 0, 0, 0, 0);
    // random traffic over a small tag space
    for (int i = 0; i < 4000; i++) begin
      bit lkv = ($urandom % 4) != 0;
      bit fv  = ($urandom % 3) == 0;
      bit fl  = ($urandom % 64) == 0;
      bit [13:0] va = va_of($urandom % 8, $urandom % 4, $urandom % 64);
      bit [7:0] vpn = 8'((($urandom % 8) << 2) | ($urandom % 4));
      step("R3", lkv, va, fv, vpn, 6'($urandom), 3'($urandom), fl);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule